// File: doc/BRIEF.md
# Keyboard Matrix Scan Encoder

The block scans a square key matrix one row at a time and reports a single pressed key as a binary code. A ring of shift-register segments, loaded at reset with one low bit, drives the rows. The low bit selects the row being scanned. A clock-enable divider turns the system clock into a slow scan tick, and the ring advances by one row on each tick while no column reads active. Column lines idle high. A key on the driven row pulls its column low.

When a column reads active on a tick, the ring stops on that row. The column pattern must then read the same for a set number of consecutive ticks. Once it does, the row index and the column index are joined into one key code, and that code is written into an output register together with a single-cycle valid strobe. A conversion memory downstream can use the strobe to fetch the code. Scanning resumes only after every column has gone back high.

Top module: `kbd_scan_encoder`

## Requirements
- R1: After reset, `rowDrive` holds only bit 0 low, `keyValid` is 0 and `keyCode` is 0.
- R2: The scan tick occurs once every `TICK_DIV` system clock cycles. The ring can move only on such a tick.
- R3: At all times exactly one bit of `rowDrive` is low. While scanning, the low bit moves from row k to row k+1 on each tick (row `ROWS-1` wraps to row 0), provided no column reads active on that tick.
- R4: If any column reads low on a tick, the ring does not move on that tick. It stays on that row until the press has been accepted and released, or until the columns read idle again before acceptance.
- R5: A press is accepted on the `DEB_TICKS`-th consecutive tick (default 4, at least 2) with the same non-idle column pattern. A changed non-idle pattern restarts the count at 1. An idle pattern before acceptance returns the block to scanning.
- R6: `keyCode` is `{row index, column index}`, 3 bits each by default: bit [5:3] is the number of the low row, bit [2:0] is the column number. The code changes only together with a strobe.
- R7: If several columns are low, the column index is that of the highest-numbered low column.
- R8: `keyValid` is high for exactly one system clock cycle per accepted press. It rises in the cycle after the accepting tick, together with the new `keyCode`.
- R9: After acceptance the ring holds its row until a tick sees all columns high. The ring moves on the next tick after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| colIn | input | COLS | Column sense lines, low means key closed on the driven row |
| rowDrive | output | ROWS | Row drives, the single low bit selects the scanned row |
| keyCode | output | CODE_W | Latched key code {row, column} |
| keyValid | output | 1 | One-cycle strobe for a newly latched code |

## Verification
The bench builds the block with an 8x8 matrix, a four-tick acceptance count and `TICK_DIV` of 5 in place of the 5 kHz divider value. With these values a full ring revolution takes 40 clocks, so wrap-around, stops on every row, multi-column presses and bounced presses all fit in a short run. A behavioural model steps the scan, debounce and release states on every clock and is compared with all outputs, including the stop on the first and last row and the highest-column priority.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  typedef struct packed {
    logic step;   // advance the ring by one row
    logic latch;  // write the key code register and raise the strobe
  } kbdCtrl_t;

  typedef enum logic [1:0] {
    ST_SCAN   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } kbdState_t;

endpackage

// File: rtl/kbd_shift_seg.sv
module kbd_shift_seg #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         serIn,
  output logic [W-1:0] q,
  output logic         serOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= INIT;
    end else if (step) begin
      q <= {q[W-2:0], serIn};
    end
  end

  assign serOut = q[W-1];

endmodule

// File: rtl/kbd_scan_dp.sv
module kbd_scan_dp
  import kbd_scan_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int SEG_W    = 4,
  parameter int TICK_DIV = 10000,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int CODE_W  = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  kbdCtrl_t          ctrl,
  input  logic [COLS-1:0]   colIn,
  output logic [ROWS-1:0]   rowDrive,
  output logic              tick,
  output logic [COLS-1:0]   colActive,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyValid
);

  localparam int NUM_SEG = ROWS / SEG_W;
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  // scan tick divider
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (divCnt == DIV_W'(TICK_DIV - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  // ring of cascaded shift segments
  logic [NUM_SEG-1:0] segOut;

  for (genvar s = 0; s < NUM_SEG; s++) begin : gSeg
    localparam logic [SEG_W-1:0] SEG_INIT =
      (s == 0) ? {{(SEG_W-1){1'b1}}, 1'b0} : {SEG_W{1'b1}};
    logic segIn;
    if (s == 0) begin : gWrap
      assign segIn = segOut[NUM_SEG-1];
    end else begin : gChain
      assign segIn = segOut[s-1];
    end
    kbd_shift_seg #(.W(SEG_W), .INIT(SEG_INIT)) u_seg (
      .clk    (clk),
      .rst    (rst),
      .step   (ctrl.step),
      .serIn  (segIn),
      .q      (rowDrive[s*SEG_W +: SEG_W]),
      .serOut (segOut[s])
    );
  end

  // encoders
  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;

  assign colActive = ~colIn;

  always_comb begin
    rowIdx = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (!rowDrive[r]) rowIdx = ROW_W'(r);
    end
  end

  always_comb begin
    colIdx = '0;
    for (int c = 0; c < COLS; c++) begin
      if (colActive[c]) colIdx = COL_W'(c);  // last hit = highest column
    end
  end

  // key code register and strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      keyCode  <= '0;
      keyValid <= 1'b0;
    end else begin
      keyValid <= ctrl.latch;
      if (ctrl.latch) keyCode <= {rowIdx, colIdx};
    end
  end

  assert_one_row_low_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(~rowDrive) == 1);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> !keyValid);

  assert_code_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !keyValid |-> $stable(keyCode));

  if (TICK_DIV > 1) begin : gTickChk
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end

endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int COLS      = 8,
  parameter int DEB_TICKS = 4,
  localparam int CNT_W    = $clog2(DEB_TICKS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [COLS-1:0] colActive,
  output kbdCtrl_t        ctrl
);

  kbdState_t       state;
  logic [COLS-1:0] colSnap;
  logic [CNT_W-1:0] stableCnt;
  logic            anyCol;
  logic            sameCols;

  assign anyCol   = |colActive;
  assign sameCols = (colActive == colSnap);

  always_comb begin
    ctrl.step  = tick && (state == ST_SCAN) && !anyCol;
    ctrl.latch = tick && (state == ST_SETTLE) && anyCol && sameCols &&
                 (stableCnt == CNT_W'(DEB_TICKS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SCAN;
      colSnap   <= '0;
      stableCnt <= '0;
    end else if (tick) begin
      case (state)
        ST_SCAN: begin
          if (anyCol) begin
            state     <= ST_SETTLE;
            colSnap   <= colActive;
            stableCnt <= CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (!anyCol) begin
            state <= ST_SCAN;
          end else if (!sameCols) begin
            colSnap   <= colActive;
            stableCnt <= CNT_W'(1);
          end else if (ctrl.latch) begin
            state <= ST_HOLD;
          end else begin
            stableCnt <= stableCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!anyCol) state <= ST_SCAN;
        end
        default: state <= ST_SCAN;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> (stableCnt != '0) && (stableCnt < CNT_W'(DEB_TICKS)));

  assert_hold_after_latch_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.latch |=> (state == ST_HOLD));

  assert_no_step_off_scan_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SCAN) |-> !ctrl.step);

endmodule

// File: rtl/kbd_scan_encoder.sv
module kbd_scan_encoder
  import kbd_scan_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int SEG_W     = 4,
  parameter int TICK_DIV  = 10000,
  parameter int DEB_TICKS = 4,
  localparam int CODE_W   = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COLS-1:0]   colIn,
  output logic [ROWS-1:0]   rowDrive,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyValid
);

  kbdCtrl_t        ctrl;
  logic            tick;
  logic [COLS-1:0] colActive;

  kbd_scan_ctrl #(.COLS(COLS), .DEB_TICKS(DEB_TICKS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .colActive (colActive),
    .ctrl      (ctrl)
  );

  kbd_scan_dp #(
    .ROWS(ROWS), .COLS(COLS), .SEG_W(SEG_W), .TICK_DIV(TICK_DIV)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .colIn     (colIn),
    .rowDrive  (rowDrive),
    .tick      (tick),
    .colActive (colActive),
    .keyCode   (keyCode),
    .keyValid  (keyValid)
  );

  assert_stop_on_press_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && (|colActive)) |=> $stable(rowDrive));

  assert_still_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(rowDrive));

endmodule

// File: tb/kbd_scan_encoder_bench.sv
module kbd_scan_encoder_bench;

  localparam int TDIV = 5;
  localparam int DEB  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] colIn;
  logic [7:0] rowDrive;
  logic [5:0] keyCode;
  logic       keyValid;

  logic [7:0] pressed [8];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int strobes = 0;

  always #10 clk = ~clk;

  kbd_scan_encoder #(
    .ROWS(8), .COLS(8), .SEG_W(4), .TICK_DIV(TDIV), .DEB_TICKS(DEB)
  ) u_kbd_scan_encoder (
    .clk(clk), .rst(rst), .colIn(colIn),
    .rowDrive(rowDrive), .keyCode(keyCode), .keyValid(keyValid)
  );

  // key matrix: a pressed key shorts its row drive onto its column
  always_comb begin
    colIn = 8'hFF;
    for (int r = 0; r < 8; r++) begin
      if (!rowDrive[r]) colIn = colIn & ~pressed[r];
    end
  end

  // behavioural reference model
  int   mDiv, mRow, mState, mCnt;
  logic [7:0] mSnap;
  int   mCode;
  bit   mValid;

  function automatic int highCol(logic [7:0] v);
    int h = 0;
    for (int c = 0; c < 8; c++) if (v[c]) h = c;
    return h;
  endfunction

  always @(posedge clk) begin
    logic [7:0] cols;
    bit tk;
    if (rst) begin
      mDiv = 0; mRow = 0; mState = 0; mCnt = 0; mSnap = '0; mCode = 0; mValid = 0;
    end else begin
      tk = (mDiv == TDIV - 1);
      mDiv = tk ? 0 : mDiv + 1;
      mValid = 0;
      cols = pressed[mRow];
      if (tk) begin
        if (mState == 0) begin
          if (cols != 0) begin mState = 1; mSnap = cols; mCnt = 1; end
          else mRow = (mRow + 1) % 8;
        end else if (mState == 1) begin
          if (cols == 0) mState = 0;
          else if (cols != mSnap) begin mSnap = cols; mCnt = 1; end
          else begin
            mCnt++;
            if (mCnt == DEB) begin
              mCode = mRow * 8 + highCol(cols);
              mValid = 1;
              mState = 2;
            end
          end
        end else begin
          if (cols == 0) mState = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(rowDrive == ~(8'd1 << mRow), "R3 rowDrive vs model", rowDrive, ~(8'd1 << mRow));
      check(keyValid == mValid, "R8 keyValid vs model", keyValid, mValid);
      check(keyCode == 6'(mCode), "R6 keyCode vs model", keyCode, mCode);
      if (keyValid) strobes++;
    end
  end

  task automatic clearKeys();
    for (int r = 0; r < 8; r++) pressed[r] = '0;
  endtask

  task automatic waitStrobe(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (keyValid) begin seen = 1; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // single key press, directed checks on code, hold and resume
  task automatic pressOne(input int r, input logic [7:0] cols, input int expCode, input string tag);
    bit seen;
    logic [7:0] held;
    int t0;
    pressed[r] = cols;
    waitStrobe(seen);
    check(seen, {tag, " strobe seen"}, seen, 1);
    check(keyCode == 6'(expCode), tag, keyCode, expCode);
    held = rowDrive;
    @(negedge clk);
    check(!keyValid, "R8 strobe one cycle", keyValid, 0);
    idle(TDIV * 6);
    check(rowDrive == held, "R9 ring held while key down", rowDrive, held);
    pressed[r] = '0;
    t0 = 0;
    while (rowDrive == held && t0 < TDIV * 4) begin @(negedge clk); t0++; end
    check(rowDrive != held, "R9 scanning resumes after release", rowDrive, held);
    check(t0 <= 2 * TDIV, "R9 resume within two ticks", t0, 2 * TDIV);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int s0, t0;
    logic [7:0] r0;
    clearKeys();
    repeat (3) @(negedge clk);
    check(rowDrive == 8'hFE, "R1 reset row", rowDrive, 8'hFE);
    check(keyValid == 1'b0, "R1 reset strobe", keyValid, 0);
    check(keyCode == 6'd0, "R1 reset code", keyCode, 0);
    rst = 1'b0;

    // R2: measure the spacing of row steps while idle
    r0 = rowDrive;
    while (rowDrive == r0) @(negedge clk);
    r0 = rowDrive; t0 = 0;
    while (rowDrive == r0) begin @(negedge clk); t0++; end
    check(t0 == TDIV, "R2 step spacing", t0, TDIV);
    idle(TDIV * 20);  // R3 wrap covered by model compare

    pressOne(5, 8'b0000_0100, 5 * 8 + 2, "R6 code row5 col2");
    pressOne(3, 8'b0100_0010, 3 * 8 + 6, "R7 highest column wins");
    pressOne(0, 8'b0000_0001, 0, "R6 code row0 col0");
    pressOne(7, 8'b1000_0000, 63, "R6 code row7 col7");

    // R5: bounce between patterns on row 2, then settle
    s0 = strobes;
    pressed[2] = 8'b0001_0000;
    while (rowDrive != 8'hFB) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      idle(TDIV * 2);
      pressed[2] = (k % 2 == 0) ? 8'b0010_0000 : 8'b0001_0000;
    end
    check(strobes == s0, "R5 no accept while bouncing", strobes, s0);
    check(rowDrive == 8'hFB, "R4 ring parked on row 2", rowDrive, 8'hFB);
    pressed[2] = 8'b0010_0000;
    waitStrobe(seen);
    check(seen && keyCode == 6'd21, "R5 accept after stable ticks", keyCode, 21);
    pressed[2] = '0;
    idle(TDIV * 4);

    // R5: short press released before acceptance gives nothing
    s0 = strobes;
    pressed[4] = 8'b0000_1000;
    while (rowDrive != 8'hEF) @(negedge clk);
    idle(TDIV * 2);
    pressed[4] = '0;
    idle(TDIV * 12);
    check(strobes == s0, "R5 short press ignored", strobes, s0);
    check(strobes == 5, "R8 one strobe per accepted press", strobes, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule